// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block watches CPU writes into the cartridge ROM address range and keeps the banking state for a cartridge built from 16 KiB ROM banks and 8 KiB external RAM banks. A write never reaches the ROM. Instead, the top three address bits pick one of four control registers: a RAM enable, a five-bit low bank field, a two-bit upper bank field and a banking-mode bit.

From that state the block produces four registered outputs. The first is the physical ROM bank for the fixed window at 0x0000–0x3FFF. The second is the ROM bank for the switchable window at 0x4000–0x7FFF. The third is the external RAM bank, and the fourth is the RAM enable. The surrounding logic uses the enable to return 0xFF on RAM reads while RAM is off. The ROM and RAM sizes come in as log2 bank counts, and every bank number is wrapped to fit them. A multicart input moves the upper field from bank bit 5 down to bank bit 4.

Top module: `rom_bank_ctrl`

## Requirements
- R1: A write is taken when `wrEn` is high. Its register is chosen by `wrAddr[15:13]`: 0 is RAM enable, 1 is the low bank, 2 is the upper bank and 3 is the mode bit. Codes 4 to 7 and cycles with `wrEn` low change nothing.
- R2: Writing 0x0A to register 0 sets `ramEnable`. Writing 0x00 clears it. Any other value leaves it unchanged.
- R3: A write to register 1 keeps `wrData[4:0]` as the low field. A value of 0 is replaced by 1 before any other masking.
- R4: When `multicart` is 0, the low field supplies switchable bank bits [4:0] and the upper field sits at bit 5. When `multicart` is 1, only low field bits [3:0] are used and the upper field sits at bit 4. In that case a low field of 0x10 gives low bits 0.
- R5: A write to register 2 keeps `wrData[1:0]` as the upper field. The switchable bank is the shifted upper field ORed with the low bits.
- R6: A write to register 3 sets the mode from `wrData[0]`. With mode 1, `lowBank` is the shifted upper field and `ramBank` is the upper field. With mode 0, both are 0.
- R7: Every ROM bank output is ANDed with (2^`romSizeLog2` − 1). `ramBank` is ANDed with (2^`ramSizeLog2` − 1).
- R8: While `rstN` is low, and after reset, `highBank` is 1, `lowBank` is 0, `ramBank` is 0 and `ramEnable` is 0.
- R9: All outputs are registered. Each output reflects a write, or a change to a size or multicart input, from the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe into the ROM range |
| wrAddr | input | 16 | Write address |
| wrData | input | 8 | Write data |
| romSizeLog2 | input | 4 | log2 of the ROM bank count |
| ramSizeLog2 | input | 2 | log2 of the RAM bank count |
| multicart | input | 1 | Upper field placed at bit 4 instead of bit 5 |
| lowBank | output | 9 | Physical bank for the fixed window |
| highBank | output | 9 | Physical bank for the switchable window |
| ramBank | output | 2 | External RAM bank |
| ramEnable | output | 1 | External RAM access enabled |

## Verification
Every result is due at the first rising edge after its stimulus. Each output register loads from the next-state values and the size masks at that edge. The bench drives a write on a falling edge, drops `wrEn` on the following falling edge and compares all four outputs there, after exactly one rising edge. Changes to the size and multicart inputs follow the same rule: the bench waits one rising edge before it compares. The checker states the same one-edge delay with `|=>` for the write-driven results.

// File: rtl/rom_bank_pkg.sv
package rom_bank_pkg;
  localparam int LOW_W = 5;
  localparam int UP_W  = 2;
  localparam int SHIFT_STD = 5;
  localparam int SHIFT_MC  = 4;

  typedef struct packed {
    logic       ramOn;
    logic       ramOff;
    logic       loadLow;
    logic       loadUp;
    logic       loadMode;
    logic [7:0] value;
  } bankStrobes_t;
endpackage

// File: rtl/rom_bank_decode.sv
module rom_bank_decode
  import rom_bank_pkg::*;
(
  input  logic         wrEn,
  input  logic [2:0]   region,
  input  logic [7:0]   wrData,
  output bankStrobes_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.value    = wrData;
    if (wrEn) begin
      unique case (region)
        3'd0: begin
          strobes.ramOn  = (wrData == 8'h0A);
          strobes.ramOff = (wrData == 8'h00);
        end
        3'd1: strobes.loadLow  = 1'b1;
        3'd2: strobes.loadUp   = 1'b1;
        3'd3: strobes.loadMode = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rom_bank_regs.sv
module rom_bank_regs
  import rom_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_LOG_W = $clog2(ROM_BANK_W + 1),
  localparam int RAM_LOG_W = $clog2(RAM_BANK_W + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bankStrobes_t          strobes,
  input  logic [ROM_LOG_W-1:0]  romSizeLog2,
  input  logic [RAM_LOG_W-1:0]  ramSizeLog2,
  input  logic                  multicart,
  output logic [ROM_BANK_W-1:0] lowBank,
  output logic [ROM_BANK_W-1:0] highBank,
  output logic [RAM_BANK_W-1:0] ramBank,
  output logic                  ramEnable
);
  logic [LOW_W-1:0] lowField, lowFieldN;
  logic [UP_W-1:0]  upField, upFieldN;
  logic             mode, modeN;
  logic             ramEnN;
  logic [ROM_BANK_W-1:0] romMask, lowPart, upShifted;
  logic [RAM_BANK_W-1:0] ramMask;
  logic [2:0] shiftAmt;
  logic unusedValue;

  assign unusedValue = ^strobes.value[7:LOW_W];

  for (genvar i = 0; i < ROM_BANK_W; i++) begin : g_romMask
    assign romMask[i] = (i < int'(romSizeLog2));
  end
  for (genvar j = 0; j < RAM_BANK_W; j++) begin : g_ramMask
    assign ramMask[j] = (j < int'(ramSizeLog2));
  end

  always_comb begin
    lowFieldN = lowField;
    if (strobes.loadLow)
      lowFieldN = (strobes.value[LOW_W-1:0] == '0) ? LOW_W'(1) : strobes.value[LOW_W-1:0];
    upFieldN = strobes.loadUp   ? strobes.value[UP_W-1:0] : upField;
    modeN    = strobes.loadMode ? strobes.value[0]        : mode;
    ramEnN   = strobes.ramOn ? 1'b1 : (strobes.ramOff ? 1'b0 : ramEnable);

    shiftAmt  = multicart ? 3'(SHIFT_MC) : 3'(SHIFT_STD);
    lowPart   = ROM_BANK_W'(lowFieldN);
    if (multicart) lowPart[LOW_W-1] = 1'b0;
    upShifted = ROM_BANK_W'(upFieldN) << shiftAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowField  <= LOW_W'(1);
      upField   <= '0;
      mode      <= 1'b0;
      ramEnable <= 1'b0;
      lowBank   <= '0;
      highBank  <= ROM_BANK_W'(1);
      ramBank   <= '0;
    end else begin
      lowField  <= lowFieldN;
      upField   <= upFieldN;
      mode      <= modeN;
      ramEnable <= ramEnN;
      highBank  <= (upShifted | lowPart) & romMask;
      lowBank   <= modeN ? (upShifted & romMask) : '0;
      ramBank   <= modeN ? (RAM_BANK_W'(upFieldN) & ramMask) : '0;
    end
  end
endmodule

// File: rtl/rom_bank_ctrl.sv
module rom_bank_ctrl
  import rom_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_LOG_W = $clog2(ROM_BANK_W + 1),
  localparam int RAM_LOG_W = $clog2(RAM_BANK_W + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [15:0]           wrAddr,
  input  logic [7:0]            wrData,
  input  logic [ROM_LOG_W-1:0]  romSizeLog2,
  input  logic [RAM_LOG_W-1:0]  ramSizeLog2,
  input  logic                  multicart,
  output logic [ROM_BANK_W-1:0] lowBank,
  output logic [ROM_BANK_W-1:0] highBank,
  output logic [RAM_BANK_W-1:0] ramBank,
  output logic                  ramEnable
);
  bankStrobes_t strobes;
  logic unusedAddr;

  assign unusedAddr = ^wrAddr[12:0];

  rom_bank_decode u_decode (
    .wrEn    (wrEn),
    .region  (wrAddr[15:13]),
    .wrData  (wrData),
    .strobes (strobes)
  );

  rom_bank_regs #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W)
  ) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .romSizeLog2 (romSizeLog2),
    .ramSizeLog2 (ramSizeLog2),
    .multicart   (multicart),
    .lowBank     (lowBank),
    .highBank    (highBank),
    .ramBank     (ramBank),
    .ramEnable   (ramEnable)
  );
endmodule

// File: rtl/rom_bank_chk.sv
module rom_bank_chk #(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_LOG_W = $clog2(ROM_BANK_W + 1),
  localparam int RAM_LOG_W = $clog2(RAM_BANK_W + 1)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [15:0]           wrAddr,
  input logic [7:0]            wrData,
  input logic [ROM_LOG_W-1:0]  romSizeLog2,
  input logic [RAM_LOG_W-1:0]  ramSizeLog2,
  input logic                  multicart,
  input logic [ROM_BANK_W-1:0] lowBank,
  input logic [ROM_BANK_W-1:0] highBank,
  input logic [RAM_BANK_W-1:0] ramBank,
  input logic                  ramEnable
);
  logic enWrite;
  assign enWrite = wrEn && (wrAddr[15:13] == 3'd0);

  AST_RAM_ON: assert property (@(posedge clk) disable iff (!rstN)
    enWrite && wrData == 8'h0A |=> ramEnable); // R2

  AST_RAM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    enWrite && wrData == 8'h00 |=> !ramEnable); // R2

  AST_RAM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(enWrite && (wrData == 8'h00 || wrData == 8'h0A)) |=> $stable(ramEnable)); // R1

  AST_MODE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr[15:13] == 3'd3 && !wrData[0] |=> lowBank == '0 && ramBank == '0); // R6

  AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $stable(romSizeLog2) |-> (highBank >> romSizeLog2) == '0); // R7
endmodule

bind rom_bank_ctrl rom_bank_chk #(
  .ROM_BANK_W (ROM_BANK_W),
  .RAM_BANK_W (RAM_BANK_W)
) u_chk (.*);

// File: tb/sim_rom_bank_ctrl.sv
module sim_rom_bank_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [3:0]  romSizeLog2 = 4'd7;
  logic [1:0]  ramSizeLog2 = 2'd2;
  logic        multicart = 1'b0;
  logic [8:0]  lowBank, highBank;
  logic [1:0]  ramBank;
  logic        ramEnable;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rom_bank_ctrl u0 (.*);

  // addr, data, expHigh, expLow, expRam, expEn
  localparam int NV = 14;
  localparam logic [44:0] VEC [NV] = '{
    {16'h0000, 8'h0A, 9'h001, 9'h000, 2'd0, 1'b1},  // R2 enable
    {16'h2000, 8'h00, 9'h001, 9'h000, 2'd0, 1'b1},  // R3 zero -> 1
    {16'h2000, 8'h13, 9'h013, 9'h000, 2'd0, 1'b1},  // R3
    {16'h2000, 8'hE7, 9'h007, 9'h000, 2'd0, 1'b1},  // R3 5-bit field
    {16'h4000, 8'h02, 9'h047, 9'h000, 2'd0, 1'b1},  // R5 mode 0
    {16'h6000, 8'h01, 9'h047, 9'h040, 2'd2, 1'b1},  // R6 mode 1
    {16'h4000, 8'h07, 9'h067, 9'h060, 2'd3, 1'b1},  // R5 R6
    {16'h3FFF, 8'h20, 9'h061, 9'h060, 2'd3, 1'b1},  // R3 masked zero
    {16'h0000, 8'h55, 9'h061, 9'h060, 2'd3, 1'b1},  // R2 hold
    {16'h6000, 8'h00, 9'h061, 9'h000, 2'd0, 1'b1},  // R6 mode 0
    {16'h1FFF, 8'h00, 9'h061, 9'h000, 2'd0, 1'b0},  // R2 disable
    {16'h8000, 8'h0A, 9'h061, 9'h000, 2'd0, 1'b0},  // R1 region 4
    {16'hA000, 8'h0A, 9'h061, 9'h000, 2'd0, 1'b0},  // R1 region 5
    {16'h7FFF, 8'hFF, 9'h061, 9'h060, 2'd3, 1'b0}   // R6 bit 0
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic checkAll(input string req, input int h, input int l, input int r, input int e);
    check({req, " highBank"}, int'(highBank), h);
    check({req, " lowBank"}, int'(lowBank), l);
    check({req, " ramBank"}, int'(ramBank), r);
    check({req, " ramEnable"}, int'(ramEnable), e);
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R8 in reset", 1, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R8 after reset", 1, 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i][44:29], VEC[i][28:21]);
      checkAll($sformatf("R9 vec%0d", i), int'(VEC[i][20:12]), int'(VEC[i][11:3]),
               int'(VEC[i][2:1]), int'(VEC[i][0]));
    end

    // R1: wrEn low ignored
    @(negedge clk);
    wrAddr = 16'h0000; wrData = 8'h0A;
    @(negedge clk);
    checkAll("R1 no strobe", 'h61, 'h60, 3, 0);

    // R7: ROM wrap to 32 banks, then RAM wrap to 2 banks
    romSizeLog2 = 4'd5;
    @(negedge clk);
    checkAll("R7 rom wrap", 'h01, 'h00, 3, 0);
    ramSizeLog2 = 2'd1;
    @(negedge clk);
    check("R7 ram wrap", int'(ramBank), 1);
    romSizeLog2 = 4'd7; ramSizeLog2 = 2'd2;

    // R4: multicart placement
    multicart = 1'b1;
    @(negedge clk);
    checkAll("R4 multicart", 'h31, 'h30, 3, 0);
    doWrite(16'h2000, 8'h10);
    check("R4 0x10 low bits", int'(highBank), 'h30);
    doWrite(16'h2000, 8'h00);
    check("R3 zero remap multicart", int'(highBank), 'h31);
    doWrite(16'h2000, 8'h1F);
    check("R4 4-bit field", int'(highBank), 'h3F);
    multicart = 1'b0;
    @(negedge clk);
    check("R4 standard", int'(highBank), 'h7F);

    // R8: reset mid-operation
    rstN = 1'b0;
    @(negedge clk);
    checkAll("R8 reapplied", 1, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule